// File: doc/BRIEF.md
# Banked Nibble-Wide Real-Time Clock

This block is a calendar clock that software reaches through a synchronous register port only four bits wide, with a four-bit address. It keeps seconds, minutes, hours, day of week, day of month, month and a two-digit year as BCD nibbles. A leap-year phase counter sets the length of February. A sub-second tick from an external prescaler enable drives an internal divider. Every `SUBDIV` ticks the divider produces one second, and the calendar advances on that second.

Sixteen addresses are shared among four banks. Two bits of the control register choose the bank. Bank 0 holds the time counters. Bank 1 holds the alarm compare nibbles, the 12/24-hour select and the leap counter. Banks 2 and 3 are two independent 13-nibble scratch memories. The control register, a test nibble and a reset/strobe register sit at the top three addresses and are visible in every bank.

A run bit in the control register stops the counters. Software clears it, reads or writes several nibbles, and sets it again. One second that falls due while the counters are stopped is held back and applied when they restart.

Top module: `nrtc_top`

## Requirements
- R1: After reset the clock reads 00:00:00, day of week 0, day 01, month 01, year 00. It is in 24-hour mode with leap counter 0, the control register reads 4'b1000 (run on, bank 0), and the reset/strobe register reads 0.
- R2: Control bits [1:0] select the bank: 0 time, 1 alarm/config, 2 memory A, 3 memory B. Addresses 0xD (control), 0xE (test) and 0xF (reset/strobe) reach the same registers in every bank. Bank-1 addresses that hold no register (0x0, 0x1, 0x9, 0xC) read 0.
- R3: A second elapses on every SUBDIV-th sub-second tick (default 16). Bank-0 addresses 0x0–0xC are, in order, seconds ones/tens, minutes ones/tens, hours ones/tens, day of week, day ones/tens, month ones/tens, year ones/tens. Seconds and minutes roll 59→00 and carry.
- R4: In 24-hour mode (bank-1 address 0xA bit 0 = 1), hours roll 23→00 and advance the day and day of week (6→0). In 12-hour mode (bit 0 = 0), hours run 12, 01 … 11. Bit 1 of the hours-tens nibble is PM and toggles on 11→12. The day advances on 11 PM→12 AM.
- R5: The day rolls to 01 after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for the other months; and for February 29 when the leap counter (bank-1 address 0xB) is 0, otherwise 28. Month 12 rolls to 01 and increments the year. Year 99 rolls to 00. Each year increment advances the leap counter modulo 4.
- R6: While control bit 3 is 0 the time counters hold. Any number of seconds that fall due during the hold are applied as exactly one second on the cycle after bit 3 returns to 1.
- R7: Writing a bank-0 address loads that nibble directly. A second that falls due in the same cycle as a write to a time or configuration register is applied one cycle later.
- R8: Memories A and B each store 13 nibbles at addresses 0x0–0xC, independently of each other and of the clock.
- R9: Writing the reset/strobe register with bit 0 set clears all alarm nibbles (bank-1 0x2–0x8). Writing it with bit 1 set restarts the sub-second divider. Bits 0 and 1 read back as 0.
- R10: Reset/strobe bit 2 enables `pulse_sub_o`, which is high for one cycle one clock after each sub-second tick. Bit 3 enables `pulse_sec_o`, which is high for one cycle one clock after each second boundary.
- R11: The test register stores and returns any nibble. Control bit 2 (alarm enable) is stored and read back with the rest of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | Sub-second enable from external prescaler |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble for bus_addr (combinational) |
| pulse_sub_o | output | 1 | Sub-second pulse output |
| pulse_sec_o | output | 1 | Once-per-second pulse output |

## Verification
The hardest states to reach from the ports are the carry boundaries: 11 PM into midnight in 12-hour mode, February 28/29 under each leap phase, and New Year's Eve of year 99. Each would take days of ticks to reach by counting. The bench instead freezes the counters, loads the nibbles one second before the boundary, restarts the divider and supplies exactly SUBDIV ticks. The other hard case is a second that falls due in the same cycle as a register write. The bench reaches it by running the divider to one tick before the boundary and then raising the tick and the write strobe on the same edge.

// File: rtl/nrtc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the banked nibble clock.
// Assumes a 4-bit data path and a 4-bit address space.
package nrtc_pkg;
    localparam int NIB = 4;

    typedef enum logic [1:0] {
        BK_TIME  = 2'd0,
        BK_ALARM = 2'd1,
        BK_RAM_A = 2'd2,
        BK_RAM_B = 2'd3
    } bank_e;

    // Nibble positions of the time counters in bank 0
    localparam int T_S1  = 0;
    localparam int T_S10 = 1;
    localparam int T_M1  = 2;
    localparam int T_M10 = 3;
    localparam int T_H1  = 4;
    localparam int T_H10 = 5;
    localparam int T_DOW = 6;
    localparam int T_D1  = 7;
    localparam int T_D10 = 8;
    localparam int T_MO1 = 9;
    localparam int T_MO10 = 10;
    localparam int T_Y1  = 11;
    localparam int T_Y10 = 12;
    localparam int T_NUM = 13;

    // Shared and bank-1 addresses
    localparam logic [3:0] A_CTRL  = 4'hD;
    localparam logic [3:0] A_TEST  = 4'hE;
    localparam logic [3:0] A_STRB  = 4'hF;
    localparam logic [3:0] A_H24   = 4'hA;
    localparam logic [3:0] A_LEAP  = 4'hB;
    localparam logic [3:0] A_ALM_LO = 4'h2;
    localparam logic [3:0] A_ALM_HI = 4'h8;
    localparam int ALM_N = 7;
endpackage

// File: rtl/nrtc_prescale.sv
`timescale 1ns/1ps
// Module: sub-second divider. Counts sub_tick_i enables and emits a
// one-cycle second strobe on the SUBDIV-th. clr_i restarts the count
// and suppresses a strobe in the same cycle. Assumes SUBDIV >= 2.
module nrtc_prescale #(
    parameter int SUBDIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_tick_i,
    input  logic clr_i,
    output logic sec_stb_o
);
    localparam int CW = $clog2(SUBDIV + 1);
    localparam logic [CW-1:0] LAST = CW'(SUBDIV - 1);

    logic [CW-1:0] cnt_q;

    // Strobe on the last tick of the division period
    assign sec_stb_o = sub_tick_i && !clr_i && (cnt_q == LAST);

    // Advance or restart the divider count
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)      cnt_q <= '0;
        else if (sub_tick_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(SUBDIV));
    // R3
    stb_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_stb_o |=> cnt_q == '0);
    // R9
    clr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
endmodule

// File: rtl/nrtc_nib_ram.sv
`timescale 1ns/1ps
// Module: small nibble scratch memory with combinational read.
// Addresses at or above DEPTH read 0 and ignore writes.
module nrtc_nib_ram #(
    parameter int DEPTH = 13,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [3:0]    wdata_i,
    output logic [3:0]    rdata_o
);
    logic [3:0] mem_q [DEPTH];
    logic       hit;

    assign hit     = addr_i < AW'(DEPTH);
    assign rdata_o = hit ? mem_q[addr_i] : 4'h0;

    // Store a nibble on an in-range write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 4'h0;
        end else if (we_i && hit) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // R8
    ram_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && hit) |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/nrtc_time_core.sv
`timescale 1ns/1ps
// Module: BCD calendar counters with hold, pending second and direct
// nibble loads. Also owns the 12/24 select and the leap phase counter.
// Assumes at most one register write per cycle from the top.
module nrtc_time_core
    import nrtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic                  sec_stb_i,
    input  logic                  tw_en_i,
    input  logic                  cw_en_i,
    input  logic [3:0]            addr_i,
    input  logic [3:0]            wdata_i,
    output logic [T_NUM-1:0][3:0] tq_o,
    output logic [1:0]            leap_o,
    output logic                  h24_o
);
    localparam logic [T_NUM*4-1:0] TQ_RST =
        ((T_NUM*4)'(1) << (4*T_D1)) | ((T_NUM*4)'(1) << (4*T_MO1));

    logic [T_NUM-1:0][3:0] tq, nx;
    logic [1:0]            lp_q, lp_nx;
    logic                  h24_q, pend_q, busy, adv;
    logic                  c_min, c_hr, c_day, c_mon, c_yr;
    logic [7:0]            dbin, mbin, mlen;

    assign tq_o   = tq;
    assign leap_o = lp_q;
    assign h24_o  = h24_q;
    assign busy   = tw_en_i || cw_en_i;
    assign adv    = run_i && !busy && (sec_stb_i || pend_q);
    assign dbin   = 8'(tq[T_D10]) * 8'd10 + 8'(tq[T_D1]);
    assign mbin   = 8'(tq[T_MO10]) * 8'd10 + 8'(tq[T_MO1]);

    // Length of the current month from the month value and leap phase
    always_comb begin
        case (mbin)
            8'd2:                          mlen = (lp_q == 2'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:       mlen = 8'd30;
            default:                       mlen = 8'd31;
        endcase
    end

    // Next calendar state one second ahead, with ripple carries
    always_comb begin
        nx = tq; lp_nx = lp_q;
        c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
        if (tq[T_S1] >= 4'd9) begin
            nx[T_S1] = 4'd0;
            if (tq[T_S10] >= 4'd5) begin nx[T_S10] = 4'd0; c_min = 1'b1; end
            else nx[T_S10] = tq[T_S10] + 4'd1;
        end else nx[T_S1] = tq[T_S1] + 4'd1;
        if (c_min) begin
            if (tq[T_M1] >= 4'd9) begin
                nx[T_M1] = 4'd0;
                if (tq[T_M10] >= 4'd5) begin nx[T_M10] = 4'd0; c_hr = 1'b1; end
                else nx[T_M10] = tq[T_M10] + 4'd1;
            end else nx[T_M1] = tq[T_M1] + 4'd1;
        end
        if (c_hr) begin
            if (h24_q) begin
                if (tq[T_H10] >= 4'd2 && tq[T_H1] >= 4'd3) begin
                    nx[T_H10] = 4'd0; nx[T_H1] = 4'd0; c_day = 1'b1;
                end else if (tq[T_H1] >= 4'd9) begin
                    nx[T_H1] = 4'd0; nx[T_H10] = tq[T_H10] + 4'd1;
                end else nx[T_H1] = tq[T_H1] + 4'd1;
            end else begin
                if (tq[T_H10][0] && tq[T_H1] == 4'd2) begin
                    nx[T_H1] = 4'd1; nx[T_H10] = {2'b00, tq[T_H10][1], 1'b0};
                end else if (tq[T_H10][0] && tq[T_H1] == 4'd1) begin
                    nx[T_H1] = 4'd2; nx[T_H10] = {2'b00, !tq[T_H10][1], 1'b1};
                    c_day = tq[T_H10][1];
                end else if (tq[T_H1] >= 4'd9) begin
                    nx[T_H1] = 4'd0; nx[T_H10] = {2'b00, tq[T_H10][1], 1'b1};
                end else nx[T_H1] = tq[T_H1] + 4'd1;
            end
        end
        if (c_day) begin
            nx[T_DOW] = (tq[T_DOW] >= 4'd6) ? 4'd0 : tq[T_DOW] + 4'd1;
            if (dbin >= mlen) begin
                nx[T_D1] = 4'd1; nx[T_D10] = 4'd0; c_mon = 1'b1;
            end else if (tq[T_D1] >= 4'd9) begin
                nx[T_D1] = 4'd0; nx[T_D10] = tq[T_D10] + 4'd1;
            end else nx[T_D1] = tq[T_D1] + 4'd1;
        end
        if (c_mon) begin
            if (mbin >= 8'd12) begin
                nx[T_MO1] = 4'd1; nx[T_MO10] = 4'd0; c_yr = 1'b1;
            end else if (tq[T_MO1] >= 4'd9) begin
                nx[T_MO1] = 4'd0; nx[T_MO10] = tq[T_MO10] + 4'd1;
            end else nx[T_MO1] = tq[T_MO1] + 4'd1;
        end
        if (c_yr) begin
            lp_nx = lp_q + 2'd1;
            if (tq[T_Y1] >= 4'd9) begin
                nx[T_Y1] = 4'd0;
                nx[T_Y10] = (tq[T_Y10] >= 4'd9) ? 4'd0 : tq[T_Y10] + 4'd1;
            end else nx[T_Y1] = tq[T_Y1] + 4'd1;
        end
    end

    // Hold at most one due second while stopped or while a write is in progress
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (!run_i || busy)   pend_q <= pend_q || sec_stb_i;
        else                       pend_q <= pend_q && sec_stb_i;
    end

    // Load written nibbles or advance the calendar
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tq    <= TQ_RST;
            lp_q  <= 2'd0;
            h24_q <= 1'b1;
        end else begin
            if (tw_en_i) tq[addr_i] <= wdata_i;
            else if (adv) begin
                tq   <= nx;
                lp_q <= lp_nx;
            end
            if (cw_en_i && addr_i == A_H24)  h24_q <= wdata_i[0];
            if (cw_en_i && addr_i == A_LEAP) lp_q  <= wdata_i[1:0];
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !busy) |=> $stable(tq));
    // R6
    pend_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && run_i && !busy && !sec_stb_i) |=> !pend_q);
    // R7
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tw_en_i |=> tq[$past(addr_i)] == $past(wdata_i));
    // R7
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sec_stb_i) |=> pend_q);
endmodule

// File: rtl/nrtc_top.sv
`timescale 1ns/1ps
// Module: top of the banked nibble clock. Decodes the 4-bit register
// port across four banks, holds control/test/strobe and alarm nibbles,
// and routes pulse outputs. One access per cycle; reads are combinational.
module nrtc_top
    import nrtc_pkg::*;
#(
    parameter int SUBDIV    = 16,
    parameter int RAM_DEPTH = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic [3:0] bus_addr,
    input  logic       bus_we,
    input  logic [3:0] bus_wdata,
    output logic [3:0] bus_rdata,
    output logic       pulse_sub_o,
    output logic       pulse_sec_o
);
    localparam int N_RAM = 2;

    logic [3:0]            ctrl_q, test_q;
    logic                  en_sub_q, en_sec_q;
    logic [3:0]            alm_q [ALM_N];
    bank_e                 bank;
    logic                  shared, in_alm, tw_en, cw_en, div_clr, sec_stb;
    logic [2:0]            alm_idx;
    logic [T_NUM-1:0][3:0] tq;
    logic [1:0]            leap;
    logic                  h24;
    logic [3:0]            ram_rd [N_RAM];

    assign bank    = bank_e'(ctrl_q[1:0]);
    assign shared  = bus_addr >= A_CTRL;
    assign in_alm  = bus_addr >= A_ALM_LO && bus_addr <= A_ALM_HI;
    assign alm_idx = 3'(bus_addr - A_ALM_LO);
    assign tw_en   = bus_we && bank == BK_TIME && bus_addr < 4'(T_NUM);
    assign cw_en   = bus_we && bank == BK_ALARM &&
                     (bus_addr == A_H24 || bus_addr == A_LEAP);
    assign div_clr = bus_we && bus_addr == A_STRB && bus_wdata[1];

    nrtc_prescale #(.SUBDIV(SUBDIV)) u_div (
        .clk(clk), .rst_n(rst_n), .sub_tick_i(sub_tick),
        .clr_i(div_clr), .sec_stb_o(sec_stb)
    );

    nrtc_time_core u_core (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl_q[3]), .sec_stb_i(sec_stb),
        .tw_en_i(tw_en), .cw_en_i(cw_en), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .tq_o(tq), .leap_o(leap), .h24_o(h24)
    );

    for (genvar g = 0; g < N_RAM; g++) begin : g_ram
        logic we_g;
        assign we_g = bus_we && !shared && ctrl_q[1:0] == 2'(g + 2);
        nrtc_nib_ram #(.DEPTH(RAM_DEPTH), .AW(4)) u_ram (
            .clk(clk), .rst_n(rst_n), .we_i(we_g), .addr_i(bus_addr),
            .wdata_i(bus_wdata), .rdata_o(ram_rd[g])
        );
    end

    // Control, test and strobe register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= 4'b1000;
            test_q   <= 4'h0;
            en_sub_q <= 1'b0;
            en_sec_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
            if (bus_addr == A_TEST) test_q <= bus_wdata;
            if (bus_addr == A_STRB) begin
                en_sub_q <= bus_wdata[2];
                en_sec_q <= bus_wdata[3];
            end
        end
    end

    // Alarm nibble storage with bulk clear from the strobe register
    always_ff @(posedge clk) begin
        if (!rst_n || (bus_we && bus_addr == A_STRB && bus_wdata[0])) begin
            for (int i = 0; i < ALM_N; i++) alm_q[i] <= 4'h0;
        end else if (bus_we && bank == BK_ALARM && in_alm) begin
            alm_q[alm_idx] <= bus_wdata;
        end
    end

    // Registered pulse outputs gated by the strobe-register enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_sub_o <= 1'b0;
            pulse_sec_o <= 1'b0;
        end else begin
            pulse_sub_o <= sub_tick && en_sub_q;
            pulse_sec_o <= sec_stb && en_sec_q;
        end
    end

    // Read multiplexer across shared registers and the selected bank
    always_comb begin
        bus_rdata = 4'h0;
        if (bus_addr == A_CTRL)      bus_rdata = ctrl_q;
        else if (bus_addr == A_TEST) bus_rdata = test_q;
        else if (bus_addr == A_STRB) bus_rdata = {en_sec_q, en_sub_q, 2'b00};
        else begin
            case (bank)
                BK_TIME:  bus_rdata = tq[bus_addr];
                BK_ALARM: begin
                    if (in_alm)                  bus_rdata = alm_q[alm_idx];
                    else if (bus_addr == A_H24)  bus_rdata = {3'b000, h24};
                    else if (bus_addr == A_LEAP) bus_rdata = {2'b00, leap};
                end
                BK_RAM_A: bus_rdata = ram_rd[0];
                BK_RAM_B: bus_rdata = ram_rd[1];
                default:  bus_rdata = 4'h0;
            endcase
        end
    end

    // R9
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_STRB && bus_wdata[0]) |=>
        (alm_q[0] == 4'h0 && alm_q[3] == 4'h0 && alm_q[ALM_N-1] == 4'h0));
    // R10
    sec_pulse_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_sec_o |-> $past(en_sec_q));
    // R10
    sub_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_sub_o |-> $past(sub_tick));
    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=> ctrl_q == $past(bus_wdata));
endmodule

// File: tb/nrtc_top_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the banked nibble clock: one task per scenario.
module nrtc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_wdata = 4'h0;
    logic [3:0] bus_rdata;
    logic       pulse_sub_o, pulse_sec_o;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    nrtc_top dut_i (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pulse_sub_o(pulse_sub_o), .pulse_sec_o(pulse_sec_o)
    );

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [3:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [3:0] exp);
        @(negedge clk); bus_we = 1'b0; bus_addr = a; #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); sub_tick = 1'b1; end
        @(negedge clk); sub_tick = 1'b0;
    endtask

    // Freeze, load hh:59:59 and the date, restart divider, run
    task automatic load_time(logic [3:0] h10, h1, dw, d10, d1, mo10, mo1, y10, y1);
        wr(4'hD, 4'b0000);
        wr(4'h0, 4'd9); wr(4'h1, 4'd5); wr(4'h2, 4'd9); wr(4'h3, 4'd5);
        wr(4'h4, h1);   wr(4'h5, h10);  wr(4'h6, dw);
        wr(4'h7, d1);   wr(4'h8, d10);  wr(4'h9, mo1); wr(4'hA, mo10);
        wr(4'hB, y1);   wr(4'hC, y10);
        wr(4'hF, 4'b0010);
        wr(4'hD, 4'b1000);
    endtask

    task automatic set_cfg(logic [3:0] a, logic [3:0] d);
        wr(4'hD, 4'b0001); wr(a, d); wr(4'hD, 4'b1000);
    endtask

    task automatic t_reset();
        rd_chk("R1 sec1", 4'h0, 4'h0); rd_chk("R1 sec10", 4'h1, 4'h0);
        rd_chk("R1 hr1", 4'h4, 4'h0);  rd_chk("R1 dow", 4'h6, 4'h0);
        rd_chk("R1 day1", 4'h7, 4'h1); rd_chk("R1 mon1", 4'h9, 4'h1);
        rd_chk("R1 yr10", 4'hC, 4'h0); rd_chk("R1 ctrl", 4'hD, 4'b1000);
        rd_chk("R1 strb", 4'hF, 4'h0);
        wr(4'hD, 4'b1001);
        rd_chk("R1 h24", 4'hA, 4'h1); rd_chk("R1 leap", 4'hB, 4'h0);
        wr(4'hD, 4'b1000);
    endtask

    task automatic t_seconds();
        wr(4'hF, 4'b0010);
        ticks(15); rd_chk("R3 no second before 16 ticks", 4'h0, 4'h0);
        ticks(1);  rd_chk("R3 second after 16 ticks", 4'h0, 4'h1);
        load_time(4'd0, 4'd0, 4'd2, 4'd1, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R3 sec10 wrap", 4'h1, 4'h0); rd_chk("R3 min1 wrap", 4'h2, 4'h0);
        rd_chk("R3 min10 wrap", 4'h3, 4'h0); rd_chk("R3 hour carry", 4'h4, 4'h1);
    endtask

    task automatic t_hours();
        load_time(4'd2, 4'd3, 4'd6, 4'd0, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R4 24h hr10", 4'h5, 4'h0); rd_chk("R4 24h hr1", 4'h4, 4'h0);
        rd_chk("R4 dow 6->0", 4'h6, 4'h0); rd_chk("R4 day 05->06", 4'h7, 4'h6);
        set_cfg(4'hA, 4'h0);
        load_time(4'b0001, 4'd1, 4'd2, 4'd0, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R4 11AM->12PM hr10", 4'h5, 4'b0011); rd_chk("R4 11AM->12PM hr1", 4'h4, 4'h2);
        rd_chk("R4 no day at noon", 4'h7, 4'h5);
        load_time(4'b0011, 4'd2, 4'd2, 4'd0, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R4 12PM->01PM hr10", 4'h5, 4'b0010); rd_chk("R4 12PM->01PM hr1", 4'h4, 4'h1);
        load_time(4'b0011, 4'd1, 4'd2, 4'd0, 4'd6, 4'd0, 4'd3, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R4 11PM->12AM hr10", 4'h5, 4'b0001); rd_chk("R4 11PM->12AM hr1", 4'h4, 4'h2);
        rd_chk("R4 midnight day", 4'h7, 4'h7);
        set_cfg(4'hA, 4'h1);
    endtask

    task automatic t_months();
        set_cfg(4'hB, 4'h0);
        load_time(4'd2, 4'd3, 4'd1, 4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R5 leap Feb 29 d10", 4'h8, 4'h2); rd_chk("R5 leap Feb 29 d1", 4'h7, 4'h9);
        load_time(4'd2, 4'd3, 4'd1, 4'd2, 4'd9, 4'd0, 4'd2, 4'd2, 4'd4);
        ticks(16);
        rd_chk("R5 Feb29->Mar d1", 4'h7, 4'h1); rd_chk("R5 Feb29->Mar mon", 4'h9, 4'h3);
        set_cfg(4'hB, 4'h1);
        load_time(4'd2, 4'd3, 4'd1, 4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd5);
        ticks(16);
        rd_chk("R5 Feb28->Mar d10", 4'h8, 4'h0); rd_chk("R5 Feb28->Mar mon", 4'h9, 4'h3);
        load_time(4'd2, 4'd3, 4'd1, 4'd3, 4'd0, 4'd0, 4'd4, 4'd2, 4'd5);
        ticks(16);
        rd_chk("R5 Apr30->May d1", 4'h7, 4'h1); rd_chk("R5 Apr30->May mon", 4'h9, 4'h5);
        set_cfg(4'hB, 4'h3);
        load_time(4'd2, 4'd3, 4'd1, 4'd3, 4'd1, 4'd1, 4'd2, 4'd9, 4'd9);
        ticks(16);
        rd_chk("R5 year wrap y1", 4'hB, 4'h0); rd_chk("R5 year wrap y10", 4'hC, 4'h0);
        rd_chk("R5 Dec->Jan mon10", 4'hA, 4'h0); rd_chk("R5 Dec->Jan mon1", 4'h9, 4'h1);
        wr(4'hD, 4'b1001);
        rd_chk("R5 leap 3->0", 4'hB, 4'h0);
        wr(4'hD, 4'b1000);
    endtask

    task automatic t_freeze();
        load_time(4'd1, 4'd0, 4'd1, 4'd1, 4'd0, 4'd0, 4'd6, 4'd2, 4'd4);
        wr(4'h0, 4'h0);
        wr(4'hD, 4'b0000);
        ticks(32);
        rd_chk("R6 held while stopped", 4'h0, 4'h0);
        wr(4'hD, 4'b1000);
        rd_chk("R6 one pending second", 4'h0, 4'h1);
        rd_chk("R6 only one second", 4'h0, 4'h1);
    endtask

    task automatic t_defer();
        load_time(4'd1, 4'd0, 4'd1, 4'd1, 4'd0, 4'd0, 4'd6, 4'd2, 4'd4);
        wr(4'h0, 4'h0);
        wr(4'hF, 4'b0010);
        ticks(15);
        @(negedge clk); sub_tick = 1'b1; bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 4'h7;
        @(negedge clk); sub_tick = 1'b0; bus_we = 1'b0;
        rd_chk("R7 loaded nibble", 4'h2, 4'h7);
        rd_chk("R7 deferred second", 4'h0, 4'h1);
    endtask

    task automatic t_ram();
        wr(4'hD, 4'b1010);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'(i));
        wr(4'hD, 4'b1011);
        for (int i = 0; i < 13; i++) wr(4'(i), 4'(15 - i));
        rd_chk("R8 B first", 4'h0, 4'hF); rd_chk("R8 B last", 4'hC, 4'h3);
        wr(4'hD, 4'b1010);
        rd_chk("R8 A first", 4'h0, 4'h0); rd_chk("R8 A mid", 4'h6, 4'h6);
        rd_chk("R8 A last", 4'hC, 4'hC);
        wr(4'hD, 4'b0000);
        rd_chk("R8 clock untouched", 4'h4, 4'h0);
        wr(4'hD, 4'b1000);
    endtask

    task automatic t_alarm();
        wr(4'hD, 4'b1001);
        for (int i = 2; i <= 8; i++) wr(4'(i), 4'h5);
        rd_chk("R9 alarm stored lo", 4'h2, 4'h5); rd_chk("R9 alarm stored hi", 4'h8, 4'h5);
        rd_chk("R2 unused bank1 addr", 4'h0, 4'h0);
        wr(4'hF, 4'b0001);
        rd_chk("R9 alarm cleared lo", 4'h2, 4'h0); rd_chk("R9 alarm cleared mid", 4'h5, 4'h0);
        rd_chk("R9 alarm cleared hi", 4'h8, 4'h0);
        rd_chk("R9 action bits read 0", 4'hF, 4'h0);
        wr(4'hD, 4'b1000);
    endtask

    task automatic t_shared();
        wr(4'hD, 4'b1110);
        wr(4'hE, 4'hA);
        rd_chk("R11 test reg", 4'hE, 4'hA);
        rd_chk("R11 alarm enable kept", 4'hD, 4'b1110);
        wr(4'hD, 4'b1000);
        rd_chk("R2 test reg in bank 0", 4'hE, 4'hA);
    endtask

    task automatic t_pulses();
        wr(4'hF, 4'b1010);
        rd_chk("R10 enable readback", 4'hF, 4'b1000);
        ticks(15);
        chk("R10 no sec pulse early", {3'b0, pulse_sec_o}, 4'h0);
        @(negedge clk); sub_tick = 1'b1;
        @(negedge clk); sub_tick = 1'b0;
        chk("R10 sec pulse", {3'b0, pulse_sec_o}, 4'h1);
        chk("R10 sub pulse disabled", {3'b0, pulse_sub_o}, 4'h0);
        @(negedge clk);
        chk("R10 sec pulse one cycle", {3'b0, pulse_sec_o}, 4'h0);
        wr(4'hF, 4'b0100);
        @(negedge clk); sub_tick = 1'b1;
        @(negedge clk); sub_tick = 1'b0;
        chk("R10 sub pulse", {3'b0, pulse_sub_o}, 4'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_seconds(); t_hours(); t_months(); t_freeze();
        t_defer(); t_ram(); t_alarm(); t_shared(); t_pulses();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule